// File: doc/BRIEF.md
# Voltage Readout Text Formatter

This block turns an 8-bit converter code, where full scale stands for 3.3 V, into a 16-character ASCII text line showing the voltage with two decimal places and a unit letter, ready for a character display. A code accepted on the valid strobe is scaled by 129 with a shift and an add. This gives a value in units of 0.1 mV. The product then passes through a sequential binary-to-decimal converter that handles one bit per clock.

When the digits are ready, the three most significant decimal digits of the five-digit result go into a fixed character template. The ten-thousands digit becomes the units of volts, followed by a point and the next two digits. The finished line is registered and announced by a one-cycle done pulse. The line keeps its value until the next conversion completes. A strobe that arrives while a conversion is running is dropped.

Top module: `volt_text_fmt`

## Requirements
- R1: While `rst` is high at a rising clock edge, after that edge `done_o` is 0 and every character of `line_o` is a space (8'h20). A reset in the middle of a conversion abandons it, and no done pulse follows for the abandoned conversion.
- R2: For an accepted code C, the product P = C*129 is formed. The shown digits are P/10000 (volts), (P/1000) mod 10 (tenths) and (P/100) mod 10 (hundredths), with integer division.
- R3: Character k (k = 0 is shown first) sits at `line_o[127-8k -: 8]`. Characters 0 and 1 are spaces, 2 is the volts digit, 3 is '.' (8'h2E), 4 is the tenths digit, 5 is the hundredths digit, 6 is a space, 7 is 'V' (8'h56), and 8 to 15 are spaces.
- R4: Each digit character is 8'h30 plus the digit value, so it always lies in 8'h30..8'h39.
- R5: A code is accepted at a rising edge where `code_vld_i` is high and no conversion is running. `done_o` is then high for exactly one cycle, in the 17th cycle after the accepting edge, and the new line appears on that same edge.
- R6: A `code_vld_i` pulse during a running conversion is ignored. It changes neither the pending result nor the number of done pulses.
- R7: `line_o` changes only on the edge that raises `done_o`, and otherwise holds its value.
- R8: Code 255 yields "  3.28 V" followed by eight spaces, and code 0 yields "  0.00 V" followed by eight spaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| code_i | input | 8 | Converter code, sampled with the strobe |
| code_vld_i | input | 1 | Strobe requesting conversion of `code_i` |
| line_o | output | 128 | 16 ASCII characters, first character in the top byte |
| done_o | output | 1 | One-cycle pulse when a new line is on `line_o` |

## Verification
The hardest situation to bring about from the ports is a second strobe that lands inside the 16-cycle conversion window. Strobes that simply follow one another never reach it, because the bench waits for each done pulse before sending again. The stimulus therefore raises a second strobe with a different code a few cycles after the first. It then checks that the line shows the first code and that no further done pulse appears. A reset is also dropped into the middle of a conversion, to confirm that the abandoned result never surfaces.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

    localparam int CODE_W      = 8;
    localparam int SCALE_SHIFT = 7;
    localparam int PROD_W      = 16;
    localparam int NDIG        = 5;
    localparam int NCHAR       = 16;
    localparam int CHAR_W      = 8;
    localparam int LINE_W      = NCHAR * CHAR_W;

    localparam int POS_VOLT  = 2;
    localparam int POS_POINT = 3;
    localparam int POS_TENTH = 4;
    localparam int POS_HUND  = 5;
    localparam int POS_UNIT  = 7;

    localparam logic [CHAR_W-1:0] ASC_SPACE = 8'h20;
    localparam logic [CHAR_W-1:0] ASC_ZERO  = 8'h30;
    localparam logic [CHAR_W-1:0] ASC_POINT = 8'h2E;
    localparam logic [CHAR_W-1:0] ASC_VOLT  = 8'h56;

    typedef logic [3:0] digit_t;

    typedef struct packed {
        digit_t volts;
        digit_t tenths;
        digit_t hundredths;
    } shown_digits_t;

    typedef enum logic {
        CNV_IDLE,
        CNV_SHIFT
    } cnv_state_e;

    function automatic digit_t plus3_if_big(digit_t d);
        return (d >= 4'd5) ? digit_t'(d + 4'd3) : d;
    endfunction

    function automatic logic [CHAR_W-1:0] digit_char(digit_t d);
        return ASC_ZERO + {4'h0, d};
    endfunction

    function automatic logic [CHAR_W-1:0] template_char(int k, shown_digits_t s);
        logic [CHAR_W-1:0] c;
        case (k)
            POS_VOLT:  c = digit_char(s.volts);
            POS_POINT: c = ASC_POINT;
            POS_TENTH: c = digit_char(s.tenths);
            POS_HUND:  c = digit_char(s.hundredths);
            POS_UNIT:  c = ASC_VOLT;
            default:   c = ASC_SPACE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vtf_scale.sv
module vtf_scale
    import vtf_pkg::*;
#(
    parameter int IN_W  = CODE_W,
    parameter int SHIFT = SCALE_SHIFT,
    parameter int OUT_W = PROD_W
) (
    input  logic [IN_W-1:0]  code_i,
    output logic [OUT_W-1:0] prod_o
);
    localparam int PAD_W = OUT_W - IN_W;

    logic [OUT_W-1:0] wide;

    assign wide   = {{PAD_W{1'b0}}, code_i};
    assign prod_o = (wide << SHIFT) + wide;

endmodule

// File: rtl/vtf_dabble.sv
module vtf_dabble
    import vtf_pkg::*;
#(
    parameter int IN_W = PROD_W,
    parameter int DIGS = NDIG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [IN_W-1:0]     bin_i,
    output logic                busy_o,
    output logic                vld_o,
    output logic [DIGS*4-1:0]   bcd_o
);
    localparam int BCD_W = DIGS * 4;
    localparam int REG_W = BCD_W + IN_W;
    localparam int CNT_W = $clog2(IN_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IN_W - 1);

    cnv_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [REG_W-1:0] work_q;
    logic [BCD_W-1:0] adj;
    logic [REG_W-1:0] work_nxt;

    for (genvar g = 0; g < DIGS; g++) begin : g_adj
        assign adj[g*4 +: 4] = plus3_if_big(work_q[IN_W + g*4 +: 4]);
    end

    assign work_nxt = {adj, work_q[IN_W-1:0]} << 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CNV_IDLE;
            cnt    <= '0;
            vld_o  <= 1'b0;
            work_q <= '0;
        end else begin
            vld_o <= 1'b0;
            case (st)
                CNV_IDLE: begin
                    if (start_i) begin
                        work_q <= {{BCD_W{1'b0}}, bin_i};
                        cnt    <= '0;
                        st     <= CNV_SHIFT;
                    end
                end
                CNV_SHIFT: begin
                    work_q <= work_nxt;
                    cnt    <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        st    <= CNV_IDLE;
                        vld_o <= 1'b1;
                    end
                end
                default: st <= CNV_IDLE;
            endcase
        end
    end

    assign busy_o = (st == CNV_SHIFT);
    assign bcd_o  = work_q[REG_W-1:IN_W];

endmodule

// File: rtl/vtf_line_pack.sv
module vtf_line_pack
    import vtf_pkg::*;
#(
    parameter int CHARS = NCHAR,
    parameter int CW    = CHAR_W
) (
    input  shown_digits_t        dig_i,
    output logic [CHARS*CW-1:0]  line_o
);
    localparam int LW = CHARS * CW;

    for (genvar k = 0; k < CHARS; k++) begin : g_char
        assign line_o[LW-1-k*CW -: CW] = template_char(k, dig_i);
    end

endmodule

// File: rtl/volt_text_fmt.sv
module volt_text_fmt
    import vtf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               code_vld_i,
    output logic [LINE_W-1:0]  line_o,
    output logic               done_o
);
    logic [PROD_W-1:0]  prod;
    logic               busy;
    logic               start;
    logic               dig_vld;
    logic [NDIG*4-1:0]  bcd;
    shown_digits_t      shown;
    logic [LINE_W-1:0]  line_nxt;

    vtf_scale #(.IN_W(CODE_W), .SHIFT(SCALE_SHIFT), .OUT_W(PROD_W)) u_scale (
        .code_i (code_i),
        .prod_o (prod)
    );

    assign start = code_vld_i & ~busy;

    vtf_dabble #(.IN_W(PROD_W), .DIGS(NDIG)) u_dabble (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .bin_i   (prod),
        .busy_o  (busy),
        .vld_o   (dig_vld),
        .bcd_o   (bcd)
    );

    assign shown.volts      = bcd[(NDIG-1)*4 +: 4];
    assign shown.tenths     = bcd[(NDIG-2)*4 +: 4];
    assign shown.hundredths = bcd[(NDIG-3)*4 +: 4];

    vtf_line_pack #(.CHARS(NCHAR), .CW(CHAR_W)) u_pack (
        .dig_i  (shown),
        .line_o (line_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_o <= {NCHAR{ASC_SPACE}};
            done_o <= 1'b0;
        end else begin
            done_o <= dig_vld;
            if (dig_vld) line_o <= line_nxt;
        end
    end

endmodule

// File: rtl/vtf_checker.sv
module vtf_checker
    import vtf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              dig_vld,
    input logic              done_o,
    input logic [LINE_W-1:0] line_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!done_o && line_o == {NCHAR{ASC_SPACE}})); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R5

    AST_DONE_FOLLOWS_DIGITS: assert property (@(posedge clk) disable iff (rst)
        dig_vld |=> done_o); // R5

    AST_NO_DONE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        busy |=> !done_o); // R6

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(line_o)); // R7

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (line_o[111:104] >= ASC_ZERO && line_o[111:104] <= 8'h39
                 && line_o[95:88]  >= ASC_ZERO && line_o[95:88]  <= 8'h39
                 && line_o[87:80]  >= ASC_ZERO && line_o[87:80]  <= 8'h39)); // R4

    AST_FIXED_MARKS: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (line_o[103:96] == ASC_POINT && line_o[71:64] == ASC_VOLT)); // R3

endmodule

bind volt_text_fmt vtf_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .dig_vld (dig_vld),
    .done_o  (done_o),
    .line_o  (line_o)
);

// File: tb/tb_volt_text_fmt.sv
module tb_volt_text_fmt;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   code_i = 8'h00;
    logic         code_vld_i = 1'b0;
    logic [127:0] line_o;
    logic         done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    localparam int NVEC = 6;
    localparam logic [7:0]   TV_CODE [NVEC] = '{8'd0, 8'd1, 8'd77, 8'd128, 8'd200, 8'd255};
    localparam logic [127:0] TV_LINE [NVEC] = '{
        "  0.00 V        ", "  0.01 V        ", "  0.99 V        ",
        "  1.65 V        ", "  2.58 V        ", "  3.28 V        "};
    localparam logic [127:0] SPACES = "                ";

    always #10 clk = ~clk;

    volt_text_fmt dut (
        .clk        (clk),
        .rst        (rst),
        .code_i     (code_i),
        .code_vld_i (code_vld_i),
        .line_o     (line_o),
        .done_o     (done_o)
    );

    function automatic logic [127:0] ref_line(int c);
        int p;
        logic [127:0] l;
        p = c * 129;
        l = SPACES;
        l[111:104] = 8'h30 + 8'(p / 10000);
        l[103:96]  = 8'h2E;
        l[95:88]   = 8'h30 + 8'((p / 1000) % 10);
        l[87:80]   = 8'h30 + 8'((p / 100) % 10);
        l[71:64]   = 8'h56;
        return l;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("%s FAIL: actual=\"%s\" (%h) expected=\"%s\" (%h)", req, act, act, exp, exp);
        end
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        code_i = c;
        code_vld_i = 1'b1;
        @(negedge clk);
        code_vld_i = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (done_o !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_dones(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (done_o === 1'b1) seen++;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("WATCHDOG FAIL: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", line_o, SPACES);
        chk("R1", {127'd0, done_o}, 128'd0);
        rst = 1'b0;

        // R2 R3 R8: vector table
        for (int i = 0; i < NVEC; i++) begin
            send(TV_CODE[i]);
            wait_done(n);
            chk("R8", line_o, TV_LINE[i]);
        end

        // R5: latency and single-cycle pulse
        send(8'd100);
        wait_done(n);
        chk("R5", 128'(n), 128'd17);
        chk("R2", line_o, ref_line(100));
        @(negedge clk);
        chk("R5", {127'd0, done_o}, 128'd0);

        // R2 R3 R4: full sweep against the reference
        for (int c = 0; c < 256; c++) begin
            send(8'(c));
            wait_done(n);
            chk("R2", line_o, ref_line(c));
        end

        // R6 R7: strobe during a running conversion
        send(8'd77);
        repeat (5) @(negedge clk);
        code_i = 8'd255;
        code_vld_i = 1'b1;
        @(negedge clk);
        code_vld_i = 1'b0;
        wait_done(n);
        chk("R6", line_o, ref_line(77));
        count_dones(30, seen);
        chk("R6", 128'(seen), 128'd0);
        chk("R7", line_o, ref_line(77));

        // R1: reset in the middle of a conversion
        send(8'd200);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", line_o, SPACES);
        chk("R1", {127'd0, done_o}, 128'd0);
        count_dones(25, seen);
        chk("R1", 128'(seen), 128'd0);
        chk("R7", line_o, SPACES);

        // R8: endpoints once more after reset
        send(8'd255);
        wait_done(n);
        chk("R8", line_o, "  3.28 V        ");
        send(8'd0);
        wait_done(n);
        chk("R8", line_o, "  0.00 V        ");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule